// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Logic

This block sits behind a seven-stage pipelined analog-to-digital converter whose stages each resolve 1.5 bits and report a 2-bit code. The stages work on one sample in turn, half a clock apart. The first stage reports on a rising clock edge, the second on the following falling edge, and so on. The block keeps each stage's code in a delay line of its own. Earlier stages get longer lines, so all seven codes of one sample reach the adder together, 3.5 clocks after the first stage's edge.

The aligned codes are combined by a ripple adder in which adjacent stages overlap by one bit. Codes are limited to 00, 01 and 10, so the carry into each position can be merged with the stage bit by an OR instead of a full add. The 8-bit sum is registered on the falling edge. A new sample can enter every clock cycle. The two clock phases are the two edges of one clock. An error flag marks any sample that carried the illegal code 11. A valid flag rises once the first sample after reset reaches the output.

Top module: `adc_digital_correction`

## Requirements
- R1: The code of stage s (s = 1 for the first, most significant stage) is sampled on a rising edge when s is odd and on a falling edge when s is even. Stage s of a sample is sampled s-1 half-cycles after that sample's stage-1 rising edge. `stage_code_i[s-1]` carries stage s, with bit 1 as the upper bit of the code.
- R2: The result for a sample appears on `dout_o` at the falling edge that comes 4 clock cycles after that sample's stage-1 rising edge. It stays there for one full cycle. Consecutive samples, one per cycle, do not mix.
- R3: For legal codes, `dout_o` equals the sum over s of code_s × 2^(7−s), where code_s is read as the unsigned number {upper bit, lower bit}.
- R4: When every stage reports 01, the result is 0x7F.
- R5: When every stage reports 10, the result is 0xFE, the largest value, with no wrap.
- R6: When every stage reports 00, the result is 0x00.
- R7: `err_o` is 1 in exactly the output cycle of a sample in which at least one stage reported 11, whichever stage that was. It is 0 for the neighbouring samples, and those samples keep correct results.
- R8: `valid_o` is 0 after reset. It becomes 1 together with the result of the sample whose stage-1 code was sampled on the first rising edge after reset release. It then stays 1 until the next reset.
- R9: `rst_n` is synchronous and active low. After two falling edges with it low, `dout_o`, `err_o` and `valid_o` are 0. Every delay line is emptied, so codes presented during reset, including 11, never reach the output. The four results that follow release are 0 with `err_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The rising edge is the first phase and the falling edge is the second. |
| rst_n | input | 1 | Synchronous reset, active low, seen on both edges. |
| stage_code_i | input | 7×2 | Stage codes. Element 0 is stage 1. |
| dout_o | output | 8 | Corrected conversion result. |
| err_o | output | 1 | The sample on `dout_o` held an illegal 11 code. |
| valid_o | output | 1 | The pipeline has filled since reset. |

## Verification
The hardest condition to reach is a steady stream in which seven different samples are in flight at once. Each one must be presented only on the edge of its own stage, so a wrong chain length or a swapped edge shows up only as mixing between neighbouring samples. The stimulus loop therefore drives the odd stages between a falling and a rising edge and the even stages between a rising and a falling edge, each with the sample that belongs to that stage at that moment. Errors are placed on the longest chain and on the shortest chain, between legal samples. Every stream also begins with a reset during which all inputs are 11. This shows that the delay lines are emptied rather than just masked.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the ADC correction pipeline.
// Assumes 1.5-bit stages reporting a 2-bit code with 11 never legal.
package adc_corr_pkg;
    localparam int STAGES = 7;
    typedef logic [1:0] stage_code_t;
    localparam stage_code_t CODE_ILLEGAL = 2'b11;
endpackage

// File: rtl/phase_delay_line.sv
`timescale 1ns/1ps
// Delay line for one stage code. Its flops alternate between the rising
// and falling clock edges. Flop j sits at half-cycle START_FALL + j,
// relative to a rising edge, so LEN flops move a code LEN-1 half-cycles
// later. Assumes the input is stable around the edge of flop 0.
module phase_delay_line
    import adc_corr_pkg::*;
#(
    parameter int START_FALL = 0,
    parameter int LEN        = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  stage_code_t d_i,
    output stage_code_t q_o
);
    for (genvar j = 0; j < LEN; j++) begin : g_flop
        stage_code_t src;
        stage_code_t q;
        if (j == 0) begin : g_head
            assign src = d_i;
        end else begin : g_link
            assign src = g_flop[j-1].q;
        end
        if (((START_FALL + j) % 2) == 0) begin : g_rise
            // Capture the code on the first phase (rising edge).
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= src;
            end
        end else begin : g_fall
            // Capture the code on the second phase (falling edge).
            always_ff @(negedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= src;
            end
        end
    end

    assign q_o = g_flop[LEN-1].q;
endmodule

// File: rtl/overlap_adder.sv
`timescale 1ns/1ps
// Combinational merge of the aligned stage codes. Adjacent stages overlap
// by one bit. Because code 11 is never legal, a stage's upper bit and the
// carry arriving at the same position are never both 1, so each carry is
// merged by an OR. codes_i[0] is the most significant stage.
module overlap_adder
    import adc_corr_pkg::*;
#(
    parameter int N     = STAGES,
    localparam int OUT_W = N + 1
) (
    input  stage_code_t [N-1:0] codes_i,
    input  logic                illegal_i,
    output logic [OUT_W-1:0]    sum_o
);
    logic [N-1:0] up_w;   // upper code bit, indexed by weight
    logic [N-1:0] lo_w;   // lower code bit, indexed by weight
    logic [N-1:0] mrg;    // stage upper bit merged with incoming carry

    for (genvar w = 0; w < N; w++) begin : g_split
        assign up_w[w] = codes_i[N-1-w][1];
        assign lo_w[w] = codes_i[N-1-w][0];
    end

    assign sum_o[0]   = lo_w[0];
    assign mrg[0]     = up_w[0];
    for (genvar p = 1; p < N; p++) begin : g_ripple
        assign sum_o[p] = mrg[p-1] ^ lo_w[p];
        assign mrg[p]   = up_w[p] | (mrg[p-1] & lo_w[p]);
    end
    assign sum_o[N] = mrg[N-1];

    logic [OUT_W-1:0] chk_sum;
    // Arithmetic reference for the merged ripple, used only by the checks.
    always_comb begin
        chk_sum = '0;
        for (int i = 0; i < N; i++) begin
            chk_sum = chk_sum + (OUT_W'(codes_i[i]) << (N - 1 - i));
        end
        if (!illegal_i) begin
            AST_SUM_MATCH: assert (sum_o == chk_sum) else $error("sum mismatch"); // R3
            for (int p = 1; p < N; p++) begin
                AST_NO_CARRY_CLASH: assert (!(up_w[p] && mrg[p-1] && lo_w[p])) else $error("carry clash"); // R3
            end
        end
    end
endmodule

// File: rtl/result_register.sv
`timescale 1ns/1ps
// Output register for the corrected word, the error flag and the valid
// flag. OUT_FALL picks the clock edge on which it captures, which must be
// the edge of the last alignment flop.
module result_register #(
    parameter int OUT_W    = 8,
    parameter int OUT_FALL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] sum_i,
    input  logic             err_i,
    input  logic             fill_i,
    output logic [OUT_W-1:0] dout_o,
    output logic             err_o,
    output logic             valid_o
);
    if (OUT_FALL != 0) begin : g_fall
        // Capture the result on the second phase (falling edge).
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                dout_o  <= '0;
                err_o   <= 1'b0;
                valid_o <= 1'b0;
            end else begin
                dout_o  <= sum_i;
                err_o   <= err_i;
                valid_o <= fill_i;
            end
        end
        AST_RST_CLEARS: assert property (@(negedge clk)
            !rst_n |=> (dout_o == '0 && !err_o && !valid_o)); // R9
        AST_VALID_STICKY: assert property (@(negedge clk) disable iff (!rst_n)
            valid_o |=> valid_o); // R8
    end else begin : g_rise
        // Capture the result on the first phase (rising edge).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dout_o  <= '0;
                err_o   <= 1'b0;
                valid_o <= 1'b0;
            end else begin
                dout_o  <= sum_i;
                err_o   <= err_i;
                valid_o <= fill_i;
            end
        end
        AST_RST_CLEARS: assert property (@(posedge clk)
            !rst_n |=> (dout_o == '0 && !err_o && !valid_o)); // R9
        AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |=> valid_o); // R8
    end
endmodule

// File: rtl/adc_digital_correction.sv
`timescale 1ns/1ps
// Digital correction for a pipelined ADC with 1.5-bit stages. Stage s is
// sampled at half-cycle s-1 after the first stage's rising edge. Its own
// delay line brings every stage to half-cycle N. The overlap adder merges
// the aligned codes, and the result is registered on the edge of half-cycle
// N+2. Assumes one rising-edge-first sample per cycle and legal codes;
// an 11 code only raises err_o.
module adc_digital_correction
    import adc_corr_pkg::*;
#(
    parameter int NUM_STAGES = STAGES,
    localparam int OUT_W     = NUM_STAGES + 1,
    localparam int OUT_FALL  = NUM_STAGES % 2,
    localparam int FILL      = (NUM_STAGES + 2) / 2 + OUT_FALL,
    localparam int CW        = $clog2(FILL + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_STAGES-1:0][1:0]       stage_code_i,
    output logic [OUT_W-1:0]                 dout_o,
    output logic                             err_o,
    output logic                             valid_o
);
    stage_code_t [NUM_STAGES-1:0] aligned;
    logic [OUT_W-1:0]             sum;
    logic                         illegal;
    logic [CW-1:0]                fill_cnt;
    logic                         fill_done;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        phase_delay_line #(
            .START_FALL(i % 2),
            .LEN       (NUM_STAGES + 1 - i)
        ) u_line (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (stage_code_i[i]),
            .q_o  (aligned[i])
        );
    end

    // Flag a sample that holds any illegal code once it is aligned.
    always_comb begin
        illegal = 1'b0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (aligned[i] == CODE_ILLEGAL) illegal = 1'b1;
        end
    end

    overlap_adder #(.N(NUM_STAGES)) u_add (
        .codes_i  (aligned),
        .illegal_i(illegal),
        .sum_o    (sum)
    );

    // Count rising edges since reset until the first sample reaches the output.
    always_ff @(posedge clk) begin
        if (!rst_n)              fill_cnt <= '0;
        else if (fill_cnt != CW'(FILL)) fill_cnt <= fill_cnt + CW'(1);
    end
    assign fill_done = (fill_cnt == CW'(FILL));

    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(FILL)); // R8

    result_register #(.OUT_W(OUT_W), .OUT_FALL(OUT_FALL)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .sum_i  (sum),
        .err_i  (illegal),
        .fill_i (fill_done),
        .dout_o (dout_o),
        .err_o  (err_o),
        .valid_o(valid_o)
    );
endmodule

// File: tb/sim_adc_digital_correction.sv
`timescale 1ns/1ps
// Bench: streams samples with the staggered stage timing, checks each
// result at its output cycle, and runs a table, a random set and resets.
module sim_adc_digital_correction;
    localparam int ST  = 7;
    localparam int LAT = 5;   // check point of sample n is before rising edge n+5

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ST-1:0][1:0] stg = '0;
    logic [ST:0]      dout;
    logic             err;
    logic             valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    adc_digital_correction u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_code_i(stg),
        .dout_o      (dout),
        .err_o       (err),
        .valid_o     (valid)
    );

    // {err, expected, codes stage1..stage7}
    localparam logic [22:0] VEC [17] = '{
        {1'b0, 8'd127, 14'b01010101010101},
        {1'b0, 8'd254, 14'b10101010101010},
        {1'b0, 8'd0,   14'b00000000000000},
        {1'b0, 8'd1,   14'b00000000000001},
        {1'b0, 8'd2,   14'b00000000000010},
        {1'b0, 8'd128, 14'b10000000000000},
        {1'b0, 8'd64,  14'b01000000000000},
        {1'b1, 8'd0,   14'b00000011000000},
        {1'b0, 8'd128, 14'b01100000000000},
        {1'b0, 8'd77,  14'b00011001001001},
        {1'b0, 8'd253, 14'b10101010101001},
        {1'b0, 8'd128, 14'b01010101010110},
        {1'b1, 8'd0,   14'b11000000000000},
        {1'b0, 8'd182, 14'b10010010010010},
        {1'b1, 8'd0,   14'b00000000000011},
        {1'b0, 8'd88,  14'b00100100011000},
        {1'b0, 8'd106, 14'b01001000100010}
    };

    logic [13:0] s_code [64];
    logic [7:0]  s_exp  [64];
    logic        s_err  [64];

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_value(input logic [13:0] c);
        int acc = 0;
        for (int i = 0; i < ST; i++) acc += int'(c[13-2*i -: 2]) << (ST - 1 - i);
        return acc[7:0];
    endfunction

    function automatic string tag_of(input logic [13:0] c);
        if (c == 14'b01010101010101) return "R4";
        if (c == 14'b10101010101010) return "R5";
        if (c == 14'b00000000000000) return "R6";
        return "R3";
    endfunction

    // Drive the stages captured on the coming edge (parity 0: rising).
    task automatic drive_half(input int m, input int parity, input int cnt);
        for (int i = parity; i < ST; i += 2) begin
            int n = m - i / 2;
            if (n >= 0 && n < cnt) stg[i] = s_code[n][13-2*i -: 2];
            else                   stg[i] = 2'b00;
        end
    endtask

    // Reset (inputs held at 11), then stream cnt samples and check each one.
    task automatic run_stream(input int cnt);
        @(negedge clk); #1.25;
        rst_n = 1'b0;
        stg   = '1;
        repeat (2) @(negedge clk);
        #1.25;
        for (int m = 0; m < cnt + LAT; m++) begin
            int n = m - LAT;
            if (m > 0) begin
                @(negedge clk); #1.25;
            end
            if (n >= 0) begin
                check(valid === 1'b1, "R8 valid", valid, 1);
                check(err === s_err[n], "R7 err", err, s_err[n]);
                if (!s_err[n])
                    check(dout === s_exp[n], {tag_of(s_code[n]), " R1 R2 result"}, dout, s_exp[n]);
            end else begin
                check(valid === 1'b0, "R8 not valid", valid, 0);
                check(dout === 8'd0 && err === 1'b0, "R9 flushed", {err, dout}, 0);
            end
            rst_n = 1'b1;
            drive_half(m, 0, cnt);
            @(posedge clk); #1.25;
            drive_half(m, 1, cnt);
        end
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // Table of vectors, covering R3 to R7.
        foreach (VEC[k]) begin
            s_code[k] = VEC[k][13:0];
            s_exp[k]  = VEC[k][21:14];
            s_err[k]  = VEC[k][22];
        end
        run_stream(17);

        // Random legal codes against the weighted-sum rule (R3).
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < ST; i++) s_code[k][13-2*i -: 2] = 2'($urandom_range(0, 2));
            s_exp[k] = ref_value(s_code[k]);
            s_err[k] = 1'b0;
        end
        run_stream(40);

        // Directed: an illegal code on a middle stage between legal neighbours (R7),
        // and extreme values back to back (R4, R5, R6).
        s_code[0] = 14'b01010101010101; s_exp[0] = 8'd127; s_err[0] = 1'b0;
        s_code[1] = 14'b01011101010101; s_exp[1] = 8'd0;   s_err[1] = 1'b1;
        s_code[2] = 14'b10101010101010; s_exp[2] = 8'd254; s_err[2] = 1'b0;
        s_code[3] = 14'b00000000000000; s_exp[3] = 8'd0;   s_err[3] = 1'b0;
        s_code[4] = 14'b10101010101010; s_exp[4] = 8'd254; s_err[4] = 1'b0;
        run_stream(5);

        report();
    end
endmodule